// File: doc/BRIEF.md
# Multiplexed Bus Demultiplexer and Address Decoder

This block sits between an 8-bit processor and the memory and I/O devices around it. The processor shares one 8-bit bus between the low address byte and the data byte. The bus carries the address while the address-strobe input `ale_i` is high and carries data once it drops. The block holds the low byte captured during the address phase and joins it to the separately driven high byte. The result is a steady 16-bit address for the whole access. It also passes the shared bus through as the data bus during the data phase.

From that address and the memory/I-O status line, the block produces three active-low chip selects:
- a ROM select for memory addresses 0000h-1FFFh;
- a RAM select for memory addresses 2000h-3FFFh;
- a select for a four-register parallel port at I/O ports 80h-83h, with a 2-bit register index.

A select asserts only while a read or write strobe is low. Memory addresses 4000h-FFFFh and all other I/O ports select nothing.

The address hold is modelled in the clock domain. While `ale_i` is high, the low byte follows the bus without delay and is also sampled at each rising clock edge. Once `ale_i` is low, the byte sampled at the last rising edge with `ale_i` high is kept.

Top module: `mux_bus_decoder`

## Requirements
- R1: While reset is active and for as long afterwards as `ale_i` stays low, `addr_o[7:0]` is 00h.
- R2: Whenever `ale_i` is 1, `addr_o[7:0]` equals `ad_i` in the same cycle.
- R3: While `ale_i` is 0, `addr_o[7:0]` holds the `ad_i` value sampled at the last rising clock edge at which `ale_i` was 1, whatever `ad_i` does.
- R4: `addr_o[15:8]` always equals `a_hi_i`.
- R5: `data_o` equals `ad_i` while `ale_i` is 0 and is 00h while `ale_i` is 1.
- R6: `rom_cs_n_o` is 0 exactly when `io_m_i` is 0 (memory cycle), at least one of `rd_n_i`/`wr_n_i` is 0, and `addr_o` is in 0000h-1FFFh.
- R7: `ram_cs_n_o` is 0 exactly when `io_m_i` is 0, a strobe is low, and `addr_o` is in 2000h-3FFFh. Memory addresses 4000h-FFFFh drive no select.
- R8: `pio_cs_n_o` is 0 exactly when `io_m_i` is 1 (I/O cycle), a strobe is low, and `addr_o[7:0]` is in 80h-83h, whatever the high byte is.
- R9: `pio_reg_o` equals `addr_o[1:0]`. The port register order is 0 = port A, 1 = port B, 2 = port C, 3 = control.
- R10: With both strobes high, all selects are 1, and at no time is more than one select at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ad_i | input | 8 | Shared low address / data bus |
| a_hi_i | input | 8 | High address byte |
| ale_i | input | 1 | Address phase strobe, high during the address phase |
| io_m_i | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| addr_o | output | 16 | Stable full address |
| data_o | output | 8 | Data bus passthrough |
| rom_cs_n_o | output | 1 | ROM select, active low |
| ram_cs_n_o | output | 1 | RAM select, active low |
| pio_cs_n_o | output | 1 | Parallel port select, active low |
| pio_reg_o | output | 2 | Parallel port register index |

## Verification
Two functions can fall in the same cycle: capture of the low address byte and decoding of a select. This happens when a strobe goes low while `ale_i` is still high. In that cycle the select must come from the live bus value, not from the byte held earlier. A second overlap occurs on the cycle `ale_i` falls while the bus switches to data, where the hold must win. The bench provokes both overlaps with directed cycles and with random strobe/ALE mixes. It judges every cycle against a behavioural model that computes region membership by integer range comparison.

// File: rtl/mbd_pkg.sv
package mbd_pkg;
    localparam int MBD_LO_W   = 8;
    localparam int MBD_HI_W   = 8;
    localparam int MBD_ADDR_W = MBD_LO_W + MBD_HI_W;

    typedef struct packed {
        logic [MBD_LO_W-1:0] lo;
    } mbd_hold_t;

    typedef struct packed {
        logic rom;
        logic ram;
        logic pio;
    } mbd_sel_t;
endpackage

// File: rtl/mbd_low_latch.sv
module mbd_low_latch
    import mbd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ale_i,
    input  logic [MBD_LO_W-1:0] ad_i,
    output logic [MBD_LO_W-1:0] lo_o
);
    mbd_hold_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (ale_i) state_d.lo = ad_i;
        // transparent while the strobe is high, held value otherwise
        lo_o = ale_i ? ad_i : state_q.lo;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end
endmodule

// File: rtl/mbd_mem_decode.sv
module mbd_mem_decode #(
    parameter int              ADDR_W   = 16,
    parameter logic [15:0]     ROM_BASE = 16'h0000,
    parameter int              ROM_LOG2 = 13,
    parameter logic [15:0]     RAM_BASE = 16'h2000,
    parameter int              RAM_LOG2 = 13
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              rom_hit_o,
    output logic              ram_hit_o
);
    localparam logic [ADDR_W-1:0] RB = ADDR_W'(ROM_BASE);
    localparam logic [ADDR_W-1:0] AB = ADDR_W'(RAM_BASE);

    always_comb begin
        rom_hit_o = (addr_i[ADDR_W-1:ROM_LOG2] == RB[ADDR_W-1:ROM_LOG2]);
        ram_hit_o = (addr_i[ADDR_W-1:RAM_LOG2] == AB[ADDR_W-1:RAM_LOG2]);
    end
endmodule

// File: rtl/mbd_io_decode.sv
module mbd_io_decode #(
    parameter int         PORT_W   = 8,
    parameter logic [7:0] IO_BASE  = 8'h80,
    parameter int         REG_LOG2 = 2
) (
    input  logic [PORT_W-1:0]   port_i,
    output logic                hit_o,
    output logic [REG_LOG2-1:0] reg_o
);
    localparam logic [PORT_W-1:0] IB = PORT_W'(IO_BASE);

    always_comb begin
        hit_o = (port_i[PORT_W-1:REG_LOG2] == IB[PORT_W-1:REG_LOG2]);
        reg_o = port_i[REG_LOG2-1:0];
    end
endmodule

// File: rtl/mux_bus_decoder.sv
module mux_bus_decoder
    import mbd_pkg::*;
#(
    parameter logic [15:0] ROM_BASE = 16'h0000,
    parameter int          ROM_LOG2 = 13,
    parameter logic [15:0] RAM_BASE = 16'h2000,
    parameter int          RAM_LOG2 = 13,
    parameter logic [7:0]  IO_BASE  = 8'h80,
    parameter int          REG_LOG2 = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [MBD_LO_W-1:0]   ad_i,
    input  logic [MBD_HI_W-1:0]   a_hi_i,
    input  logic                  ale_i,
    input  logic                  io_m_i,
    input  logic                  rd_n_i,
    input  logic                  wr_n_i,
    output logic [MBD_ADDR_W-1:0] addr_o,
    output logic [MBD_LO_W-1:0]   data_o,
    output logic                  rom_cs_n_o,
    output logic                  ram_cs_n_o,
    output logic                  pio_cs_n_o,
    output logic [REG_LOG2-1:0]   pio_reg_o
);
    logic [MBD_LO_W-1:0] lo;
    logic                rom_hit, ram_hit, io_hit;
    logic                strobe;
    mbd_sel_t            sel;

    mbd_low_latch u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .ale_i (ale_i),
        .ad_i  (ad_i),
        .lo_o  (lo)
    );

    mbd_mem_decode #(
        .ADDR_W   (MBD_ADDR_W),
        .ROM_BASE (ROM_BASE),
        .ROM_LOG2 (ROM_LOG2),
        .RAM_BASE (RAM_BASE),
        .RAM_LOG2 (RAM_LOG2)
    ) u_mem (
        .addr_i    (addr_o),
        .rom_hit_o (rom_hit),
        .ram_hit_o (ram_hit)
    );

    mbd_io_decode #(
        .PORT_W   (MBD_LO_W),
        .IO_BASE  (IO_BASE),
        .REG_LOG2 (REG_LOG2)
    ) u_io (
        .port_i (lo),
        .hit_o  (io_hit),
        .reg_o  (pio_reg_o)
    );

    always_comb begin
        addr_o  = {a_hi_i, lo};
        data_o  = ale_i ? '0 : ad_i;
        strobe  = !rd_n_i || !wr_n_i;
        sel.rom = strobe && !io_m_i && rom_hit;
        sel.ram = strobe && !io_m_i && ram_hit;
        sel.pio = strobe &&  io_m_i && io_hit;
        rom_cs_n_o = !sel.rom;
        ram_cs_n_o = !sel.ram;
        pio_cs_n_o = !sel.pio;
    end
endmodule

// File: rtl/mux_bus_decoder_chk.sv
module mux_bus_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  ad_i,
    input logic [7:0]  a_hi_i,
    input logic        ale_i,
    input logic        io_m_i,
    input logic        rd_n_i,
    input logic        wr_n_i,
    input logic [15:0] addr_o,
    input logic [7:0]  data_o,
    input logic        rom_cs_n_o,
    input logic        ram_cs_n_o,
    input logic        pio_cs_n_o,
    input logic [1:0]  pio_reg_o
);
    p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ale_i |-> addr_o[7:0] == ad_i);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ale_i && $past(rst_n)) |-> $stable(addr_o[7:0]));

    p_high_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        addr_o[15:8] == a_hi_i);

    p_data_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !ale_i |-> data_o == ad_i);

    p_rom_region_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_cs_n_o |-> (addr_o[15:13] == 3'b000 && !io_m_i));

    p_ram_region_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_cs_n_o |-> (addr_o[15:13] == 3'b001 && !io_m_i));

    p_io_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !pio_cs_n_o |-> (io_m_i && addr_o[7:2] == 6'b100000));

    p_reg_index_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pio_cs_n_o |-> pio_reg_o == addr_o[1:0]);

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_n_i && wr_n_i) |-> (rom_cs_n_o && ram_cs_n_o && pio_cs_n_o));

    p_one_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!rom_cs_n_o, !ram_cs_n_o, !pio_cs_n_o}) <= 1);
endmodule

bind mux_bus_decoder mux_bus_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ad_i       (ad_i),
    .a_hi_i     (a_hi_i),
    .ale_i      (ale_i),
    .io_m_i     (io_m_i),
    .rd_n_i     (rd_n_i),
    .wr_n_i     (wr_n_i),
    .addr_o     (addr_o),
    .data_o     (data_o),
    .rom_cs_n_o (rom_cs_n_o),
    .ram_cs_n_o (ram_cs_n_o),
    .pio_cs_n_o (pio_cs_n_o),
    .pio_reg_o  (pio_reg_o)
);

// File: tb/mux_bus_decoder_tb.sv
`timescale 1ns/1ps
module mux_bus_decoder_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  ad = 8'h00, hi = 8'h00;
    logic        ale = 1'b0, iom = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
    logic [15:0] addr_o;
    logic [7:0]  data_o;
    logic        rom_cs_n, ram_cs_n, pio_cs_n;
    logic [1:0]  pio_reg;

    int checks = 0;
    int errors = 0;
    int held = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    mux_bus_decoder u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ad_i       (ad),
        .a_hi_i     (hi),
        .ale_i      (ale),
        .io_m_i     (iom),
        .rd_n_i     (rd_n),
        .wr_n_i     (wr_n),
        .addr_o     (addr_o),
        .data_o     (data_o),
        .rom_cs_n_o (rom_cs_n),
        .ram_cs_n_o (ram_cs_n),
        .pio_cs_n_o (pio_cs_n),
        .pio_reg_o  (pio_reg)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference, compared every cycle
    always begin
        int lo, full, strobe, e_rom, e_ram, e_pio;
        @(posedge clk);
        if (!rst_n) held = 0;
        else if (ale) held = int'(ad);
        #2;
        lo     = ale ? int'(ad) : held;
        full   = int'(hi) * 256 + lo;
        strobe = (!rd_n || !wr_n) ? 1 : 0;
        e_rom  = (!iom && strobe == 1 && full <= 8191) ? 0 : 1;
        e_ram  = (!iom && strobe == 1 && full >= 8192 && full <= 16383) ? 0 : 1;
        e_pio  = (iom && strobe == 1 && lo >= 128 && lo <= 131) ? 0 : 1;
        if (!done) begin
            check(ale ? "R2 low byte follows" : "R3 low byte held", int'(addr_o[7:0]), lo);
            check("R4 high byte", int'(addr_o[15:8]), int'(hi));
            check("R5 data passthrough", int'(data_o), ale ? 0 : int'(ad));
            check("R6 rom select", int'(rom_cs_n), e_rom);
            check("R7 ram select", int'(ram_cs_n), e_ram);
            check("R8 port select", int'(pio_cs_n), e_pio);
            check("R9 register index", int'(pio_reg), lo % 4);
            if (strobe == 0)
                check("R10 idle selects", int'({rom_cs_n, ram_cs_n, pio_cs_n}), 7);
        end
    end

    task automatic drive(input logic [7:0] a, input logic [7:0] h, input logic l,
                         input logic m, input logic r, input logic w);
        @(negedge clk);
        ad = a; hi = h; ale = l; iom = m; rd_n = r; wr_n = w;
    endtask

    // address phase, then two strobe cycles with changing data, then idle
    task automatic access(input logic [15:0] a, input logic m, input logic wr);
        drive(a[7:0], a[15:8], 1'b1, m, 1'b1, 1'b1);
        drive(8'h5A, a[15:8], 1'b0, m, wr, !wr);
        drive(8'hC3, a[15:8], 1'b0, m, wr, !wr);
        drive(8'h3C, a[15:8], 1'b0, m, 1'b1, 1'b1);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] mem_pts [10];
        logic [7:0]  io_pts [8];
        mem_pts = '{16'h0000, 16'h1FFF, 16'h2000, 16'h3FFF, 16'h4000,
                    16'hFFFF, 16'h8000, 16'h0083, 16'h1000, 16'h3000};
        io_pts  = '{8'h00, 8'h7F, 8'h80, 8'h81, 8'h82, 8'h83, 8'h84, 8'hFF};
        repeat (3) @(negedge clk);
        #3 check("R1 reset low byte", int'(addr_o[7:0]), 0);
        @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        #3 check("R1 low byte after reset", int'(addr_o[7:0]), 0);
        // every boundary with both status polarities and both strobes
        foreach (mem_pts[i]) begin
            access(mem_pts[i], 1'b0, 1'b0);
            access(mem_pts[i], 1'b1, 1'b1);
        end
        foreach (io_pts[i]) begin
            access({8'h00, io_pts[i]}, 1'b1, 1'b0);
            access({io_pts[i], io_pts[i]}, 1'b1, 1'b1);
            access({8'h20, io_pts[i]}, 1'b0, 1'b0);
        end
        // strobe low while the address strobe is still high
        drive(8'h81, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1);
        drive(8'h10, 8'h00, 1'b1, 1'b1, 1'b0, 1'b1);
        drive(8'h99, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1);
        drive(8'hFF, 8'h20, 1'b1, 1'b0, 1'b1, 1'b0);
        drive(8'h00, 8'h20, 1'b0, 1'b0, 1'b1, 1'b0);
        // random mixes
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r;
            r = $urandom;
            drive(r[7:0], {r[15:14], 3'b000, r[10:8]} | (r[20] ? r[31:24] : 8'h00),
                  r[16], r[17], r[18], r[19] | !r[18]);
        end
        drive(8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule